// File: doc/BRIEF.md
# Gate Sweep Acquisition Sequencer

This block drives a time-gated image sensor through a sweep of gate positions. A start command captures the configuration and launches a run. The run visits every gate position in turn. For each position the block puts out a sub-clock delay code. It then builds the gate image from a fixed number of single-bit frames. The exposure of each frame stays open for a programmed number of 400 ns windows, and a strobe marks the end of every frame.

The delay code begins at a programmable offset and rises by one unit for each new gate. One unit is one fifty-sixth of the reference period. A deep mode takes four images per gate instead of one. A preview mode overrides the configuration: it runs a single set and never uses the deep mode. At each frame boundary the downstream buffer can hold the sweep back. An abort command ends the run at once.

Top module: `gate_sweep_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `exposureEn`, `frameStrobe`, `gateDone` and `runDone` are all low.
- R2: A `startCmd` seen while idle captures the configuration and raises `busy` at the next clock edge. `busy` stays high through the strobe of the last frame of the last gate. In the following cycle `busy` is low and `runDone` is high for exactly one cycle.
- R3: The run visits `cfgSets * cfgGatesPerSet` gates. In normal mode each gate gets `FRAMES_PER_IMAGE` frames (255 by default). `gateDone` is high only together with the strobe of the last frame of a gate.
- R4: When `cfgExtended` is 1, each gate gets 4 * `FRAMES_PER_IMAGE` frames, and `gateDone` comes only after the last of them.
- R5: When `previewMode` is 1 at start, the run uses one set and normal depth, whatever `cfgSets` and `cfgExtended` hold.
- R6: During gate number k (counting from 0), `delayCode` equals `cfgOffset + k`. It does not change while `exposureEn` stays high.
- R7: When `cfgOffset + k` is greater than 2^CODE_W - 1, `delayCode` holds at 2^CODE_W - 1 and `codeError` goes high. `codeError` stays high until the next start.
- R8: Each frame's exposure (`exposureEn` high) lasts `cfgExposure * WINDOW_CYCLES` clock cycles. A `cfgExposure` of 0 behaves as 1.
- R9: `frameStrobe` is a single-cycle pulse in the cycle after the exposure ends. If `bufReady` is low in that strobe cycle, the next exposure does not begin until `bufReady` is high again.
- R10: `abortCmd` sends the block to idle at the next clock edge, and that run produces no `runDone`.
- R11: A `cfgSets` or `cfgGatesPerSet` of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startCmd | input | 1 | Start a run (used only when idle) |
| abortCmd | input | 1 | Abort the current run |
| previewMode | input | 1 | Preview: one set, normal depth |
| cfgOffset | input | CODE_W | Delay code of the first gate |
| cfgSets | input | SET_W | Number of sets |
| cfgGatesPerSet | input | GPS_W | Gates per set |
| cfgExposure | input | EXP_W | Exposure windows per frame |
| cfgExtended | input | 1 | Four images per gate |
| bufReady | input | 1 | Downstream buffer can accept the next frame |
| delayCode | output | CODE_W | Gate delay code |
| exposureEn | output | 1 | Gate exposure active |
| frameStrobe | output | 1 | End of a single-bit frame |
| gateDone | output | 1 | Last frame of the current gate |
| busy | output | 1 | Run in progress |
| runDone | output | 1 | One-cycle pulse when a run completes |
| codeError | output | 1 | Delay code saturated during this run |

## Verification
The bench predicts the delay code, the `gateDone` flag and the exposure length of every frame, and compares each of them at its strobe. It covers the following cases, each paired with the mistake it exposes:
- An offset near full scale: a design that wraps instead of clamping would show small codes and leave `codeError` low.
- Preview applied over a deep, multi-set configuration: a design that leaks either setting would produce extra frames, which the scoreboard reports.
- Exposure, set and gate counts of zero: a design that does not treat these as one would hang, or would run an exposure of the wrong length.
- A buffer stall: a design that ignores the stall would start the next exposure early.
- An abort during the first exposure: a design that ignores it would stay busy, or would report a completion.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXPOSE = 2'd1,
    ST_STROBE = 2'd2,
    ST_STALL  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic load;
    logic expTick;
    logic frameEnd;
  } ctrlStrobes_t;
endpackage

// File: rtl/gs_datapath.sv
module gs_datapath
  import gs_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SET_W = 8,
  parameter int GPS_W = 8,
  parameter int EXP_W = 12,
  parameter int FRAMES_PER_IMAGE = 255,
  parameter int WINDOW_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              previewMode,
  input  logic [CODE_W-1:0] cfgOffset,
  input  logic [SET_W-1:0]  cfgSets,
  input  logic [GPS_W-1:0]  cfgGatesPerSet,
  input  logic [EXP_W-1:0]  cfgExposure,
  input  logic              cfgExtended,
  output logic              expDone,
  output logic              gateLast,
  output logic              runLast,
  output logic [CODE_W-1:0] delayCode,
  output logic              codeError
);
  localparam int IDX_W = SET_W + GPS_W;
  localparam int FR_W = $clog2(FRAMES_PER_IMAGE + 1);
  localparam int SUM_W = ((CODE_W > IDX_W) ? CODE_W : IDX_W) + 1;
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [FR_W-1:0] FRAME_LAST = FR_W'(FRAMES_PER_IMAGE - 1);

  logic [EXP_W-1:0]  effExp;
  logic              effExt;
  logic [IDX_W-1:0]  totalM1;
  logic [CODE_W-1:0] offsetQ;
  logic [EXP_W-1:0]  winCnt;
  logic [FR_W-1:0]   frameCnt;
  logic [1:0]        passCnt;
  logic [IDX_W-1:0]  gateIdx;
  logic              windowEnd;
  logic              lastWin;
  logic              frameLast;
  logic              passLast;

  logic [SET_W-1:0]  loadSets;
  logic [GPS_W-1:0]  loadGps;
  logic [IDX_W-1:0]  loadTotal;
  logic [SUM_W-1:0]  sumNext;

  // Apply the preview and zero-means-one rules to the configuration at start.
  always_comb begin
    if (previewMode) loadSets = SET_W'(1);
    else if (cfgSets == '0) loadSets = SET_W'(1);
    else loadSets = cfgSets;
    loadGps = (cfgGatesPerSet == '0) ? GPS_W'(1) : cfgGatesPerSet;
    loadTotal = IDX_W'(loadSets) * IDX_W'(loadGps);
  end

  // Window cycle counter; none is built when one window is a single cycle.
  generate
    if (WINDOW_CYCLES == 1) begin : g_noCycCnt
      assign windowEnd = 1'b1;
    end else begin : g_cycCnt
      localparam int CYC_W = $clog2(WINDOW_CYCLES);
      logic [CYC_W-1:0] cycCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cycCnt <= '0;
        else if (strobes.load) cycCnt <= '0;
        else if (strobes.expTick) begin
          if (cycCnt == CYC_W'(WINDOW_CYCLES - 1)) cycCnt <= '0;
          else cycCnt <= cycCnt + 1'b1;
        end
      end
      assign windowEnd = (cycCnt == CYC_W'(WINDOW_CYCLES - 1));
    end
  endgenerate

  assign lastWin   = (winCnt == effExp - 1'b1);
  assign expDone   = windowEnd && lastWin;
  assign frameLast = (frameCnt == FRAME_LAST);
  assign passLast  = (passCnt == (effExt ? 2'd3 : 2'd0));
  assign gateLast  = frameLast && passLast;
  assign runLast   = gateLast && (gateIdx == totalM1);
  assign sumNext   = SUM_W'(offsetQ) + SUM_W'(gateIdx) + SUM_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effExp    <= EXP_W'(1);
      effExt    <= 1'b0;
      totalM1   <= '0;
      offsetQ   <= '0;
      winCnt    <= '0;
      frameCnt  <= '0;
      passCnt   <= '0;
      gateIdx   <= '0;
      delayCode <= '0;
      codeError <= 1'b0;
    end else if (strobes.load) begin
      effExp    <= (cfgExposure == '0) ? EXP_W'(1) : cfgExposure;
      effExt    <= cfgExtended && !previewMode;
      totalM1   <= loadTotal - 1'b1;
      offsetQ   <= cfgOffset;
      winCnt    <= '0;
      frameCnt  <= '0;
      passCnt   <= '0;
      gateIdx   <= '0;
      delayCode <= cfgOffset;
      codeError <= 1'b0;
    end else begin
      if (strobes.expTick && windowEnd) begin
        winCnt <= lastWin ? '0 : winCnt + 1'b1;
      end
      if (strobes.frameEnd) begin
        frameCnt <= frameLast ? '0 : frameCnt + 1'b1;
        if (frameLast) passCnt <= passLast ? 2'd0 : passCnt + 1'b1;
        if (gateLast && !runLast) begin
          gateIdx <= gateIdx + 1'b1;
          if (sumNext > SUM_W'(CODE_MAX)) begin
            delayCode <= CODE_MAX;
            codeError <= 1'b1;
          end else begin
            delayCode <= CODE_W'(sumNext);
          end
        end
      end
    end
  end

  // R7
  err_rise_on_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(codeError) |-> $past(strobes.frameEnd));

  // R6
  code_hold_in_exposure_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.expTick && $past(strobes.expTick)) |-> $stable(delayCode));
endmodule

// File: rtl/gs_ctrl.sv
module gs_ctrl
  import gs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startCmd,
  input  logic         abortCmd,
  input  logic         bufReady,
  input  logic         expDone,
  input  logic         gateLast,
  input  logic         runLast,
  output ctrlStrobes_t strobes,
  output logic         exposureEn,
  output logic         frameStrobe,
  output logic         gateDone,
  output logic         busy,
  output logic         runDone
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (startCmd) stateNext = ST_EXPOSE;
      ST_EXPOSE: if (expDone) stateNext = ST_STROBE;
      ST_STROBE: begin
        if (runLast) stateNext = ST_IDLE;
        else if (bufReady) stateNext = ST_EXPOSE;
        else stateNext = ST_STALL;
      end
      ST_STALL:  if (bufReady) stateNext = ST_EXPOSE;
      default:   stateNext = ST_IDLE;
    endcase
    if (abortCmd) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      runDone <= 1'b0;
    end else begin
      state   <= stateNext;
      runDone <= (state == ST_STROBE) && runLast && !abortCmd;
    end
  end

  always_comb begin
    strobes.load     = (state == ST_IDLE) && startCmd && !abortCmd;
    strobes.expTick  = (state == ST_EXPOSE);
    strobes.frameEnd = (state == ST_STROBE);
  end

  assign exposureEn  = (state == ST_EXPOSE);
  assign frameStrobe = (state == ST_STROBE);
  assign gateDone    = (state == ST_STROBE) && gateLast;
  assign busy        = (state != ST_IDLE);

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> !frameStrobe);

  // R3
  gate_done_with_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateDone |-> frameStrobe);

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortCmd |=> (!busy && !runDone));

  // R2
  run_done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    runDone |-> (!busy && $past(frameStrobe)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && !bufReady) |=> !exposureEn);

  // R8
  expose_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    exposureEn |-> busy);
endmodule

// File: rtl/gate_sweep_seq.sv
module gate_sweep_seq
  import gs_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SET_W = 8,
  parameter int GPS_W = 8,
  parameter int EXP_W = 12,
  parameter int FRAMES_PER_IMAGE = 255,
  parameter int WINDOW_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCmd,
  input  logic              abortCmd,
  input  logic              previewMode,
  input  logic [CODE_W-1:0] cfgOffset,
  input  logic [SET_W-1:0]  cfgSets,
  input  logic [GPS_W-1:0]  cfgGatesPerSet,
  input  logic [EXP_W-1:0]  cfgExposure,
  input  logic              cfgExtended,
  input  logic              bufReady,
  output logic [CODE_W-1:0] delayCode,
  output logic              exposureEn,
  output logic              frameStrobe,
  output logic              gateDone,
  output logic              busy,
  output logic              runDone,
  output logic              codeError
);
  ctrlStrobes_t strobes;
  logic expDone, gateLast, runLast;

  gs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .abortCmd(abortCmd),
    .bufReady(bufReady), .expDone(expDone), .gateLast(gateLast),
    .runLast(runLast), .strobes(strobes), .exposureEn(exposureEn),
    .frameStrobe(frameStrobe), .gateDone(gateDone), .busy(busy),
    .runDone(runDone)
  );

  gs_datapath #(
    .CODE_W(CODE_W), .SET_W(SET_W), .GPS_W(GPS_W), .EXP_W(EXP_W),
    .FRAMES_PER_IMAGE(FRAMES_PER_IMAGE), .WINDOW_CYCLES(WINDOW_CYCLES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .previewMode(previewMode),
    .cfgOffset(cfgOffset), .cfgSets(cfgSets), .cfgGatesPerSet(cfgGatesPerSet),
    .cfgExposure(cfgExposure), .cfgExtended(cfgExtended), .expDone(expDone),
    .gateLast(gateLast), .runLast(runLast), .delayCode(delayCode),
    .codeError(codeError)
  );
endmodule

// File: tb/gate_sweep_seq_tb_top.sv
module gate_sweep_seq_tb_top;
  localparam int CODE_W = 6;
  localparam int SET_W = 3;
  localparam int GPS_W = 3;
  localparam int EXP_W = 4;
  localparam int FRAMES = 4;
  localparam int WIN = 2;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic clk = 0;
  logic rstN = 0;
  logic startCmd = 0, abortCmd = 0, previewMode = 0, cfgExtended = 0;
  logic bufReady = 1;
  logic [CODE_W-1:0] cfgOffset = '0;
  logic [SET_W-1:0] cfgSets = '0;
  logic [GPS_W-1:0] cfgGatesPerSet = '0;
  logic [EXP_W-1:0] cfgExposure = '0;
  logic [CODE_W-1:0] delayCode;
  logic exposureEn, frameStrobe, gateDone, busy, runDone, codeError;

  int checks = 0;
  int fails = 0;
  int expCnt = 0;
  int expCycles = 0;
  int runDoneCnt = 0;
  int expQ[$];

  always #10 clk = ~clk;

  gate_sweep_seq #(
    .CODE_W(CODE_W), .SET_W(SET_W), .GPS_W(GPS_W), .EXP_W(EXP_W),
    .FRAMES_PER_IMAGE(FRAMES), .WINDOW_CYCLES(WIN)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .abortCmd(abortCmd),
    .previewMode(previewMode), .cfgOffset(cfgOffset), .cfgSets(cfgSets),
    .cfgGatesPerSet(cfgGatesPerSet), .cfgExposure(cfgExposure),
    .cfgExtended(cfgExtended), .bufReady(bufReady), .delayCode(delayCode),
    .exposureEn(exposureEn), .frameStrobe(frameStrobe), .gateDone(gateDone),
    .busy(busy), .runDone(runDone), .codeError(codeError)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: compares every frame strobe with the next expected item.
  always @(negedge clk) begin
    if (rstN) begin
      if (exposureEn) expCnt++;
      if (runDone) runDoneCnt++;
      if (gateDone && !frameStrobe) check("R3 gateDone without strobe", 1, 0);
      if (frameStrobe) begin
        if (expQ.size() == 0) begin
          check("R3 unexpected frame", 1, 0);
        end else begin
          int item;
          item = expQ.pop_front();
          check("R6 delayCode", int'(delayCode), item >> 1);
          check("R3 R4 gateDone", int'(gateDone), item & 1);
          check("R8 exposure cycles", expCnt, expCycles);
        end
        expCnt = 0;
      end
    end
  end

  // Driver: pushes the expected frames of one run and starts it.
  task automatic runSeq(input int off, input int sets, input int gps,
                        input int ex, input bit ext, input bit prev,
                        input bit stall, input string tag);
    int effSets, effGps, passes, total, doneBefore;
    effSets = prev ? 1 : ((sets == 0) ? 1 : sets);
    effGps = (gps == 0) ? 1 : gps;
    passes = (ext && !prev) ? 4 : 1;
    total = effSets * effGps;
    expCycles = ((ex == 0) ? 1 : ex) * WIN;
    for (int g = 0; g < total; g++)
      for (int p = 0; p < passes; p++)
        for (int f = 0; f < FRAMES; f++) begin
          int code;
          code = (off + g > CODE_MAX) ? CODE_MAX : off + g;
          expQ.push_back(code * 2 + ((p == passes - 1 && f == FRAMES - 1) ? 1 : 0));
        end
    cfgOffset = CODE_W'(off);
    cfgSets = SET_W'(sets);
    cfgGatesPerSet = GPS_W'(gps);
    cfgExposure = EXP_W'(ex);
    cfgExtended = ext;
    previewMode = prev;
    bufReady = !stall;
    doneBefore = runDoneCnt;
    startCmd = 1;
    @(negedge clk);
    startCmd = 0;
    check({tag, " R2 busy after start"}, int'(busy), 1);
    if (stall) begin
      while (!frameStrobe) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        check({tag, " R9 stall holds exposure"}, int'(exposureEn || frameStrobe), 0);
        check({tag, " R9 busy in stall"}, int'(busy), 1);
      end
      bufReady = 1;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check({tag, " R2 runDone pulses"}, runDoneCnt - doneBefore, 1);
    check({tag, " R3 all frames seen"}, expQ.size(), 0);
    check({tag, " R7 codeError"}, int'(codeError), (off + total - 1 > CODE_MAX) ? 1 : 0);
    expQ.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int doneBefore;
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 exposureEn", int'(exposureEn), 0);
    check("R1 frameStrobe", int'(frameStrobe), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 idle after release", int'(busy || runDone || gateDone), 0);

    runSeq(5, 2, 2, 3, 0, 0, 0, "normal");
    runSeq(0, 1, 2, 1, 1, 0, 0, "extended R4");
    runSeq(9, 3, 2, 2, 1, 1, 0, "preview R5");
    runSeq(7, 0, 0, 0, 0, 0, 0, "zeros R11 R8");
    runSeq(62, 1, 3, 1, 0, 0, 0, "saturate R7");
    runSeq(1, 1, 2, 2, 0, 0, 1, "stall R9");
    runSeq(3, 1, 1, 1, 0, 0, 0, "after error R7");

    // Abort during the first exposure (R10).
    cfgExposure = EXP_W'(15);
    cfgSets = SET_W'(2);
    cfgGatesPerSet = GPS_W'(2);
    doneBefore = runDoneCnt;
    startCmd = 1;
    @(negedge clk);
    startCmd = 0;
    repeat (4) @(negedge clk);
    abortCmd = 1;
    @(negedge clk);
    abortCmd = 0;
    check("R10 busy after abort", int'(busy), 0);
    check("R10 exposure after abort", int'(exposureEn), 0);
    repeat (40) @(negedge clk);
    check("R10 no runDone", runDoneCnt - doneBefore, 0);
    check("R10 still idle", int'(busy), 0);
    expCnt = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule